// File: doc/BRIEF.md
# PCM Frame Geometry Measurement Unit

This block watches the three conditioned strobes of a PCM telemetry stream (word start, minor frame start and major frame start) together with a one-cycle bit tick, all synchronous to the system clock. It does not need to be told the stream format. It learns the format by counting between consecutive rising edges of the strobes. It then holds the bits per word, the words per minor frame and the minor frames per major frame in three format registers.

Each format register has a lock flag, the way a decommutator reports lock. A flag comes on only after two equal measurements in a row. It drops as soon as a measurement disagrees with the stored value, or as soon as its counter overflows. The unit also counts bit ticks over a fixed gate taken from a divider on the system clock, which gives the incoming bit rate once per gate. It emits a one-cycle freeze pulse when each major frame begins, so that an external time source can be latched.

Control software reads every result through a plain combinational register port. This port has no handshake and no back-pressure: `rd_data` follows `rd_addr` in the same cycle. No streaming data passes through the block.

Top module: `pcm_geom_meas`

## Requirements
- R1: The bits register (address 0) holds the number of `bit_tick` pulses seen from one rising edge of `fb_strb` up to the next. A tick in the cycle of the opening edge counts. A tick in the cycle of the closing edge counts toward the next span.
- R2: The words register (address 1) holds the number of `fb_strb` rising edges from one `minor_strb` rising edge up to the next, with the same inclusion rule as R1.
- R3: The frames register (address 2) holds the number of `minor_strb` rising edges from one `major_strb` rising edge up to the next, with the same inclusion rule as R1.
- R4: The first closing edge after reset only arms a measurement and loads nothing. Each later closing edge loads the register. The lock flag is set when the loaded value equals the value held before, and is cleared when it differs. Lock flags are output on `word_lock`, `minor_lock` and `major_lock`.
- R5: A span counter that receives a tick while already at its maximum (2^width − 1) saturates and clears its lock flag at once. At the closing edge of that span the register keeps its old value. After that, two fresh equal measurements are needed to lock again. A span of exactly 2^width − 1 ticks still measures correctly.
- R6: The rate register (address 3) is loaded every `GATE_CYCLES` clock cycles with the number of `bit_tick` pulses in that gate. A tick in the last cycle of the gate belongs to the gate that is closing.
- R7: `freeze` is high for exactly one cycle, in the cycle after the one in which `major_strb` is first sampled high following a low sample.
- R8: The read port is combinational. Address 4 returns the status word, with bit 0 = word lock, bit 1 = minor lock and bit 2 = major lock. Addresses 5 to 7 return zero.
- R9: A synchronous active-high `rst` clears all counters, registers, lock flags and the freeze output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per received bit |
| fb_strb | input | 1 | Word first-bit strobe (level) |
| minor_strb | input | 1 | Minor frame strobe (level) |
| major_strb | input | 1 | Major frame strobe (level) |
| rd_addr | input | 3 | Register select |
| rd_data | output | 32 | Selected register, zero-extended |
| word_lock | output | 1 | Bits-per-word lock |
| minor_lock | output | 1 | Words-per-minor-frame lock |
| major_lock | output | 1 | Minor-frames-per-major-frame lock |
| freeze | output | 1 | Time-latch pulse at major frame start |

## Verification
The close of a rate gate can land in the same cycle as a bit tick. R6 says that tick belongs to the gate that is closing. To provoke this, the bench drives the bit tick in every cycle for several gates, so every gate boundary carries a tick. It then expects the rate to equal the gate length exactly. During random streams, a monitor in the bench keeps its own gate count from reset. The rate read back after each stream is compared with that monitor's total, so boundaries that do and do not coincide with a tick are both judged.

// File: rtl/pcm_geom_pkg.sv
package pcm_geom_pkg;

  localparam int RD_W   = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_BITS   = 3'd0,
    REG_WORDS  = 3'd1,
    REG_FRAMES = 3'd2,
    REG_RATE   = 3'd3,
    REG_STATUS = 3'd4
  } reg_sel_e;

  localparam int ST_WORD  = 0;
  localparam int ST_MINOR = 1;
  localparam int ST_MAJOR = 2;

  // strobe index inside the edge detector vector
  localparam int SIDX_FB    = 0;
  localparam int SIDX_MINOR = 1;
  localparam int SIDX_MAJOR = 2;
  localparam int NSTRB      = 3;

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/pcm_span_meas.sv
module pcm_span_meas #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         close,
  output logic [W-1:0] value,
  output logic         lock
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] val_q;
  logic         armed_q;
  logic         have_q;
  logic         ovf_q;
  logic         lock_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      val_q   <= '0;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
      ovf_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else if (close) begin
      cnt_q   <= W'(tick);
      ovf_q   <= 1'b0;
      armed_q <= 1'b1;
      if (armed_q && !ovf_q) begin
        lock_q <= have_q && (cnt_q == val_q);
        val_q  <= cnt_q;
        have_q <= 1'b1;
      end else if (ovf_q) begin
        have_q <= 1'b0;
        lock_q <= 1'b0;
      end
    end else if (tick) begin
      if (at_max) begin
        ovf_q  <= 1'b1;
        lock_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign value = val_q;
  assign lock  = lock_q;

  // R5
  ovf_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> !lock_q);

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (at_max && tick && !close) |=> (cnt_q == CNT_MAX));

  // R4
  lock_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(close));

  // R4
  val_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(val_q) |-> $past(close));

endmodule

// File: rtl/pcm_rate_meas.sv
module pcm_rate_meas #(
  parameter int GATE_CYCLES = 100_000_000,
  parameter int RATE_W      = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [RATE_W-1:0] rate
);

  localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0]     GATE_LAST = GW'(GATE_CYCLES - 1);
  localparam logic [RATE_W-1:0] ACC_MAX   = {RATE_W{1'b1}};

  logic [GW-1:0]     gate_q;
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W-1:0] acc_nxt;
  logic [RATE_W-1:0] rate_q;
  logic              gate_end;

  assign gate_end = (gate_q == GATE_LAST);
  assign acc_nxt  = (acc_q == ACC_MAX) ? acc_q : acc_q + RATE_W'(tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      acc_q  <= '0;
      rate_q <= '0;
    end else if (gate_end) begin
      gate_q <= '0;
      acc_q  <= '0;
      rate_q <= acc_nxt;
    end else begin
      gate_q <= gate_q + 1'b1;
      acc_q  <= acc_nxt;
    end
  end

  assign rate = rate_q;

  // R6
  rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate_q) |-> $past(gate_end));

  // R6
  gate_bound_chk: assert property (@(posedge clk) disable iff (rst)
    gate_q <= GATE_LAST);

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gate_end |=> (acc_q == '0));

endmodule

// File: rtl/pcm_geom_meas.sv
module pcm_geom_meas
  import pcm_geom_pkg::*;
#(
  parameter int BIT_W       = 6,
  parameter int WORD_W      = 10,
  parameter int FRAME_W     = 8,
  parameter int RATE_W      = 28,
  parameter int GATE_CYCLES = 100_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              fb_strb,
  input  logic              minor_strb,
  input  logic              major_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data,
  output logic              word_lock,
  output logic              minor_lock,
  output logic              major_lock,
  output logic              freeze
);

  logic [NSTRB-1:0]   lvl;
  logic [NSTRB-1:0]   rise;
  logic [BIT_W-1:0]   bits_val;
  logic [WORD_W-1:0]  words_val;
  logic [FRAME_W-1:0] frames_val;
  logic [RATE_W-1:0]  rate_val;
  logic               wl, ml, jl;
  logic               freeze_q;

  assign lvl[SIDX_FB]    = fb_strb;
  assign lvl[SIDX_MINOR] = minor_strb;
  assign lvl[SIDX_MAJOR] = major_strb;

  pcm_edge_det #(.N(NSTRB)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .rise(rise)
  );

  // R1: bit ticks between word starts
  pcm_span_meas #(.W(BIT_W)) u_bits (
    .clk  (clk),
    .rst  (rst),
    .tick (bit_tick),
    .close(rise[SIDX_FB]),
    .value(bits_val),
    .lock (wl)
  );

  // R2: word starts between minor frame starts
  pcm_span_meas #(.W(WORD_W)) u_words (
    .clk  (clk),
    .rst  (rst),
    .tick (rise[SIDX_FB]),
    .close(rise[SIDX_MINOR]),
    .value(words_val),
    .lock (ml)
  );

  // R3: minor frame starts between major frame starts
  pcm_span_meas #(.W(FRAME_W)) u_frames (
    .clk  (clk),
    .rst  (rst),
    .tick (rise[SIDX_MINOR]),
    .close(rise[SIDX_MAJOR]),
    .value(frames_val),
    .lock (jl)
  );

  pcm_rate_meas #(.GATE_CYCLES(GATE_CYCLES), .RATE_W(RATE_W)) u_rate (
    .clk (clk),
    .rst (rst),
    .tick(bit_tick),
    .rate(rate_val)
  );

  always_ff @(posedge clk) begin
    if (rst) freeze_q <= 1'b0;
    else     freeze_q <= rise[SIDX_MAJOR];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_BITS:   rd_data = RD_W'(bits_val);
      REG_WORDS:  rd_data = RD_W'(words_val);
      REG_FRAMES: rd_data = RD_W'(frames_val);
      REG_RATE:   rd_data = RD_W'(rate_val);
      REG_STATUS: begin
        rd_data[ST_WORD]  = wl;
        rd_data[ST_MINOR] = ml;
        rd_data[ST_MAJOR] = jl;
      end
      default:    rd_data = '0;
    endcase
  end

  assign word_lock  = wl;
  assign minor_lock = ml;
  assign major_lock = jl;
  assign freeze     = freeze_q;

  // R7
  freeze_single_chk: assert property (@(posedge clk) disable iff (rst)
    freeze_q |=> !freeze_q);

  // R7
  freeze_src_chk: assert property (@(posedge clk) disable iff (rst)
    freeze_q |-> $past(major_strb));

endmodule

// File: tb/sim_pcm_geom_meas.sv
module sim_pcm_geom_meas;

  localparam int G  = 97;
  localparam int BW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, fb = 1'b0, mn = 1'b0, mj = 1'b0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic        wl, ml, jl, frz;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pcm_geom_meas #(.BIT_W(BW), .GATE_CYCLES(G)) u0 (
    .clk(clk), .rst(rst), .bit_tick(tick), .fb_strb(fb), .minor_strb(mn),
    .major_strb(mj), .rd_addr(rd_addr), .rd_data(rd_data),
    .word_lock(wl), .minor_lock(ml), .major_lock(jl), .freeze(frz)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_status(input bit w, input bit m, input bit j);
    return int'({j, m, w});
  endfunction

  // monitor: gate model (R6) and freeze timing (R7)
  int   gate_n = 0, acc = 0, exp_rate = 0;
  logic mj_prev = 1'b0;
  logic mon_rise = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      gate_n = 0; acc = 0; exp_rate = 0; mj_prev = 1'b0; mon_rise = 1'b0;
    end else begin
      mon_rise = mj & ~mj_prev;
      mj_prev  = mj;
      if (gate_n == G - 1) begin
        exp_rate = acc + int'(tick); acc = 0; gate_n = 0;
      end else begin
        acc += int'(tick); gate_n++;
      end
    end
    #2;
    if (mon_rise) chk(frz == 1'b1, "R7 freeze pulse", int'(frz), 1);
    else if (frz !== 1'b0) chk(1'b0, "R7 freeze idle", int'(frz), 0);
  end

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    tick = 1'b0;
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic bitp(input bit f, input bit m, input bit j, input int per);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      tick = (i == 0); fb = f; mn = m; mj = j;
    end
  endtask

  task automatic span(input int n);
    for (int b = 0; b < n; b++) bitp(b == 0, 1'b0, 1'b0, 1);
  endtask

  task automatic stream(input int bpw, input int wpm, input int mpj, input int per);
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < mpj; f++)
        for (int w = 0; w < wpm; w++)
          for (int b = 0; b < bpw; b++)
            bitp(b == 0, w == 0, f == 0, per);
    bitp(1'b1, 1'b1, 1'b1, per);
    bitp(1'b0, 1'b0, 1'b0, per);
  endtask

  task automatic check_all(input int bpw, input int wpm, input int mpj);
    int v;
    rd(3'd0, v); chk(v == bpw, "R1 bits per word", v, bpw);
    rd(3'd1, v); chk(v == wpm, "R2 words per minor", v, wpm);
    rd(3'd2, v); chk(v == mpj, "R3 minors per major", v, mpj);
    rd(3'd4, v); chk(v == exp_status(1, 1, 1), "R4 R8 status locked", v, exp_status(1, 1, 1));
    rd(3'd3, v); chk(v == exp_rate, "R6 rate", v, exp_rate);
  endtask

  task automatic check_cleared(input string tag);
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, tag, v, 0);
    end
    chk({wl, ml, jl, frz} == 4'b0, tag, int'({wl, ml, jl, frz}), 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int bpw, wpm, mpj, per;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 / R8: reset state, unmapped addresses read zero
    check_cleared("R9 R8 reset state");

    // R4 R5: directed lock and overflow sequence on word spans
    repeat (4) span(8);
    rd(3'd0, v); chk(v == 8, "R4 bits after lock", v, 8);
    chk(wl == 1'b1, "R4 word lock set", int'(wl), 1);
    span(20);
    rd(3'd0, v); chk(v == 8, "R5 value held in overflow", v, 8);
    chk(wl == 1'b0, "R5 lock cleared on overflow", int'(wl), 0);
    span(8);
    rd(3'd0, v); chk(v == 8, "R5 overflow span not loaded", v, 8);
    chk(wl == 1'b0, "R5 no lock after overflow close", int'(wl), 0);
    span(8);
    bitp(1'b1, 1'b0, 1'b0, 1);
    rd(3'd4, v); chk(v == exp_status(1, 0, 0), "R4 relock after two", v, exp_status(1, 0, 0));
    repeat (4) bitp(1'b0, 1'b0, 1'b0, 1);
    bitp(1'b1, 1'b0, 1'b0, 1);
    rd(3'd0, v); chk(v == 5, "R4 mismatch loads", v, 5);
    chk(wl == 1'b0, "R4 mismatch unlocks", int'(wl), 0);
    repeat (14) bitp(1'b0, 1'b0, 1'b0, 1);
    bitp(1'b1, 1'b0, 1'b0, 1);
    bitp(1'b0, 1'b0, 1'b0, 1);
    rd(3'd0, v); chk(v == 15, "R5 maximum span", v, 15);

    // R6: tick in every cycle so each gate end coincides with a tick
    for (int i = 0; i < 3 * G; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    rd(3'd3, v); chk(v == G, "R6 full-rate gate", v, G);
    chk(exp_rate == G, "R6 monitor gate", exp_rate, G);

    // R1 R2 R3 R4 R6 R7: minimal corner, then random formats
    stream(2, 2, 2, 1);
    check_all(2, 2, 2);
    for (int s = 0; s < 7; s++) begin
      bpw = 2 + int'($urandom % 11);
      wpm = 2 + int'($urandom % 5);
      mpj = 2 + int'($urandom % 3);
      per = 1 + int'($urandom % 3);
      stream(bpw, wpm, mpj, per);
      check_all(bpw, wpm, mpj);
    end
    stream(12, 6, 4, 2);
    check_all(12, 6, 4);

    // R9: reset during operation clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_cleared("R9 mid-run reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule